// File: doc/BRIEF.md
# Control Block Command Sequencer

This block keeps the command word and the completion state of a single control block that software places in memory-mapped space. A write of the low command word carries a set of packed fields: start bit, mode, transfer type, two access attributes, opcode and extended opcode. When that write has its start bit set and the block is not busy, the block checks the command's legality. It then either launches execution or records an exception at once.

Execution itself happens outside the block. The block raises a one-cycle launch pulse. It then waits in the active state until the executor answers with a done or error indication, together with a substatus and a cause vector. When execution ends, the block reports one of three statuses: idle, exception, or operating-system-assistance. A classifier marks an exception as retryable when its causes are all transient ones. An optional one-cycle interrupt request pulse can be raised when a command completes.

Top module: `cb_sequencer`

## Requirements
- R1: After reset `rd_data` and `cmd_word` are 0, which is idle status and no causes, and `exec_go` and `irq` are low.
- R2: A command write with bit 0 set, an opcode (bits 23:16) below 0x10 and a permitted mode is accepted when the status is not active. On the next clock edge the status (`rd_data[1:0]`) becomes 2 (active). On that same edge `exec_go` pulses high for exactly one cycle, and the substatus, cause vector and overrun flag are cleared.
- R3: `exec_done` while active sets the status to 0 (idle) and latches `exec_sub` into the substatus (`rd_data[5:2]`). The low three substatus bits carry a queue result code from 0 to 5, and bit 3 flags an implicit abort.
- R4: `exec_err` with a nonzero `exec_cause` while active sets the status to 1 (exception). It latches the 18-bit cause vector into `rd_data[23:6]` and the substatus from `exec_sub`. Error takes priority over done.
- R5: `exec_err` with an all-zero cause vector while active sets the status to 3 (call-OS).
- R6: An accepted start whose opcode is 0x10 or above does not launch. `exec_go` stays low, the status becomes 1, and cause bit 1 (`rd_data[7]`) is set.
- R7: Mode bits are command bits 3:1. Mode bit 1 (command bit 2) requests unmapped operation. If this bit is set while `priv` is low, the start does not launch, the status becomes 1 and cause bit 2 (`rd_data[8]`) is set. With `priv` high the same command launches normally.
- R8: `rd_data[24]` (retryable) is 1 only when the status is 1 and the cause vector is nonzero with every set bit among bits 8, 9, 10 and 16. Otherwise it is 0.
- R9: A command write while the status is active is ignored: the status and `cmd_word` are unchanged. If that write has its start bit set, the sticky overrun flag `rd_data[25]` is set and stays set until the next accepted start. A write without the start bit while not active only updates `cmd_word`.
- R10: Mode bit 2 (command bit 3) requests an interrupt. `irq` pulses for one cycle on the edge where such a command completes, whether by done, by error, or by immediate rejection under R6 or R7. Without that bit, `irq` stays low.
- R11: `exec_done` and `exec_err` have no effect while the status is not active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Write strobe for the low command word |
| cmd_wdata | input | 32 | Command word written |
| priv | input | 1 | Writer is privileged (unmapped mode permitted) |
| exec_done | input | 1 | Executor reports normal completion |
| exec_err | input | 1 | Executor reports an error |
| exec_cause | input | 18 | Cause vector accompanying an error |
| exec_sub | input | 4 | Substatus accompanying completion |
| exec_go | output | 1 | One-cycle launch pulse to the executor |
| irq | output | 1 | One-cycle interrupt request pulse |
| cmd_word | output | 32 | Stored command word |
| rd_data | output | 32 | Status 1:0, substatus 5:2, cause 23:6, retryable 24, overrun 25 |

## Verification
The properties assume the executor answers only while the block is active. They also assume `exec_done` and `exec_err` are single-cycle strobes, and that a command write is a single-cycle strobe sampled at the rising edge. The stimulus drives every input just after a rising edge and drops each strobe after one cycle. It raises done or error only after it has seen a launch. The exceptions are the deliberate idle-time strobes used to show that they are ignored.

// File: rtl/cb_pkg.sv
package cb_pkg;
  localparam int CAUSE_W  = 18;
  localparam int SUB_W    = 4;
  localparam int OPC_LIM  = 16;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_EXC    = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_CALLOS = 2'd3
  } cb_status_e;

  // Command word field positions.
  localparam int F_START = 0;
  localparam int F_UNMAP = 2;
  localparam int F_INTR  = 3;
  localparam int F_OPC_L = 16;
  localparam int F_OPC_H = 23;

  // Cause bit positions raised by the block itself.
  localparam int C_BADOP = 1;
  localparam int C_UNMAP = 2;

  function automatic logic wants_irq(input logic [31:0] w);
    return w[F_INTR];
  endfunction
endpackage

// File: rtl/cb_cmd_check.sv
module cb_cmd_check
  import cb_pkg::*;
#(
  parameter int CW  = CAUSE_W,
  parameter int LIM = OPC_LIM
) (
  input  logic [31:0]   word,
  input  logic          priv,
  output logic [CW-1:0] bad_cause
);
  logic [7:0] opc;

  always_comb begin
    opc = word[F_OPC_H:F_OPC_L];
    bad_cause = '0;
    if (32'(opc) >= LIM)        bad_cause[C_BADOP] = 1'b1;
    if (word[F_UNMAP] && !priv) bad_cause[C_UNMAP] = 1'b1;
  end
endmodule

// File: rtl/cb_retry_class.sv
module cb_retry_class
  import cb_pkg::*;
#(
  parameter int            CW   = CAUSE_W,
  parameter logic [CW-1:0] MASK = CW'((1 << 16) | (1 << 10) | (1 << 9) | (1 << 8))
) (
  input  logic [1:0]    status,
  input  logic [CW-1:0] cause,
  output logic          retryable
);
  always_comb begin
    retryable = (status == ST_EXC) && (|cause) && ((cause & ~MASK) == '0);
  end
endmodule

// File: rtl/cb_state_regs.sv
module cb_state_regs
  import cb_pkg::*;
#(
  parameter int CW = CAUSE_W,
  parameter int SW = SUB_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic [31:0]   cmd_wdata,
  input  logic [CW-1:0] bad_cause,
  input  logic          exec_done,
  input  logic          exec_err,
  input  logic [CW-1:0] exec_cause,
  input  logic [SW-1:0] exec_sub,
  output logic [1:0]    status,
  output logic [SW-1:0] sub,
  output logic [CW-1:0] cause,
  output logic          ovr,
  output logic [31:0]   cmd,
  output logic          go,
  output logic          irq
);
  cb_status_e    st_q, st_n;
  logic [SW-1:0] sub_q, sub_n;
  logic [CW-1:0] cause_q, cause_n;
  logic          ovr_q, ovr_n;
  logic [31:0]   cmd_q, cmd_n;
  logic          go_n, irq_n, go_q, irq_q;
  logic          busy, accept;

  always_comb begin
    busy    = (st_q == ST_ACTIVE);
    accept  = cmd_we && cmd_wdata[F_START] && !busy;
    st_n    = st_q;
    sub_n   = sub_q;
    cause_n = cause_q;
    ovr_n   = ovr_q;
    cmd_n   = cmd_q;
    go_n    = 1'b0;
    irq_n   = 1'b0;

    if (cmd_we && !busy) cmd_n = cmd_wdata;
    if (cmd_we && cmd_wdata[F_START] && busy) ovr_n = 1'b1;

    if (accept) begin
      ovr_n = 1'b0;
      sub_n = '0;
      if (|bad_cause) begin
        st_n    = ST_EXC;
        cause_n = bad_cause;
        irq_n   = wants_irq(cmd_wdata);
      end else begin
        st_n    = ST_ACTIVE;
        cause_n = '0;
        go_n    = 1'b1;
      end
    end else if (busy && exec_err) begin
      st_n    = (|exec_cause) ? ST_EXC : ST_CALLOS;
      cause_n = exec_cause;
      sub_n   = exec_sub;
      irq_n   = wants_irq(cmd_q);
    end else if (busy && exec_done) begin
      st_n  = ST_IDLE;
      sub_n = exec_sub;
      irq_n = wants_irq(cmd_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      sub_q   <= '0;
      cause_q <= '0;
      ovr_q   <= 1'b0;
      cmd_q   <= '0;
      go_q    <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      st_q    <= st_n;
      sub_q   <= sub_n;
      cause_q <= cause_n;
      ovr_q   <= ovr_n;
      cmd_q   <= cmd_n;
      go_q    <= go_n;
      irq_q   <= irq_n;
    end
  end

  assign status = st_q;
  assign sub    = sub_q;
  assign cause  = cause_q;
  assign ovr    = ovr_q;
  assign cmd    = cmd_q;
  assign go     = go_q;
  assign irq    = irq_q;
endmodule

// File: rtl/cb_sequencer.sv
module cb_sequencer
  import cb_pkg::*;
#(
  parameter int CW = CAUSE_W,
  parameter int SW = SUB_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic [31:0]   cmd_wdata,
  input  logic          priv,
  input  logic          exec_done,
  input  logic          exec_err,
  input  logic [CW-1:0] exec_cause,
  input  logic [SW-1:0] exec_sub,
  output logic          exec_go,
  output logic          irq,
  output logic [31:0]   cmd_word,
  output logic [31:0]   rd_data
);
  localparam int P_SUB   = 2;
  localparam int P_CAUSE = P_SUB + SW;
  localparam int P_RETRY = P_CAUSE + CW;
  localparam int P_OVR   = P_RETRY + 1;
  localparam int USED    = P_OVR + 1;

  logic [1:0]    rst_sync;
  logic          rst_i;
  logic [CW-1:0] bad_cause, cause;
  logic [SW-1:0] sub;
  logic [1:0]    status;
  logic          ovr, retry;

  // Reset asserts at once, releases two edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  cb_cmd_check #(.CW(CW)) u_chk (
    .word(cmd_wdata), .priv(priv), .bad_cause(bad_cause)
  );

  cb_state_regs #(.CW(CW), .SW(SW)) u_regs (
    .clk(clk), .rst_n(rst_i), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .bad_cause(bad_cause), .exec_done(exec_done), .exec_err(exec_err),
    .exec_cause(exec_cause), .exec_sub(exec_sub), .status(status),
    .sub(sub), .cause(cause), .ovr(ovr), .cmd(cmd_word),
    .go(exec_go), .irq(irq)
  );

  cb_retry_class #(.CW(CW)) u_cls (
    .status(status), .cause(cause), .retryable(retry)
  );

  always_comb begin
    rd_data = '0;
    rd_data[1:0]                 = status;
    rd_data[P_CAUSE-1:P_SUB]     = sub;
    rd_data[P_RETRY-1:P_CAUSE]   = cause;
    rd_data[P_RETRY]             = retry;
    rd_data[USED-1]              = ovr;
  end
endmodule

// File: rtl/cb_sequencer_chk.sv
module cb_sequencer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_we,
  input logic [31:0] cmd_wdata,
  input logic        exec_done,
  input logic        exec_err,
  input logic        exec_go,
  input logic        irq,
  input logic [31:0] rd_data
);
  assert_go_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    exec_go |=> !exec_go);

  assert_go_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    exec_go |-> rd_data[1:0] == 2'd2);

  assert_hold_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[1:0] == 2'd2 && !exec_done && !exec_err) |=> rd_data[1:0] == 2'd2);

  assert_badop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[1:0] != 2'd2 && cmd_we && cmd_wdata[0] && cmd_wdata[23:16] > 8'h0F)
      |=> (rd_data[1:0] == 2'd1 && rd_data[7] && !exec_go));

  assert_retry_exc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[24] |-> rd_data[1:0] == 2'd1);

  assert_irq_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> rd_data[1:0] != 2'd2);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[1:0] != 2'd2 && !cmd_we) |=> $stable(rd_data[1:0]));
endmodule

bind cb_sequencer cb_sequencer_chk u_sva (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
  .exec_done(exec_done), .exec_err(exec_err), .exec_go(exec_go),
  .irq(irq), .rd_data(rd_data)
);

// File: tb/sim_cb_sequencer.sv
`timescale 1ns/1ps
module sim_cb_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic        priv = 1'b0;
  logic        exec_done = 1'b0;
  logic        exec_err = 1'b0;
  logic [17:0] exec_cause = '0;
  logic [3:0]  exec_sub = '0;
  logic        exec_go, irq;
  logic [31:0] cmd_word, rd_data;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;
  logic [31:0] exp_cmd = '0;

  typedef struct {
    logic [31:0] rd;
    logic [31:0] cw;
    logic        go;
    logic        ir;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  cb_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .priv(priv), .exec_done(exec_done), .exec_err(exec_err),
    .exec_cause(exec_cause), .exec_sub(exec_sub), .exec_go(exec_go),
    .irq(irq), .cmd_word(cmd_word), .rd_data(rd_data)
  );

  // Monitor: compares every queued expectation at the falling edge.
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (rd_data !== e.rd || cmd_word !== e.cw || exec_go !== e.go || irq !== e.ir) begin
        errors++;
        $display("FAIL %s: rd=%h cmd=%h go=%b irq=%b expected rd=%h cmd=%h go=%b irq=%b",
                 e.tag, rd_data, cmd_word, exec_go, irq, e.rd, e.cw, e.go, e.ir);
      end
    end
  end

  task automatic push(input logic [31:0] rd, input logic go, input logic ir, input string tag);
    exp_t e;
    e.rd = rd; e.cw = exp_cmd; e.go = go; e.ir = ir; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic step();
    @(posedge clk); #1;
    cmd_we = 1'b0; exec_done = 1'b0; exec_err = 1'b0;
  endtask

  task automatic wr(input logic [31:0] w, input logic p, input logic taken);
    cmd_we = 1'b1; cmd_wdata = w; priv = p;
    if (taken) exp_cmd = w;
    step();
  endtask

  task automatic done(input logic [3:0] s);
    exec_done = 1'b1; exec_sub = s; step();
  endtask

  task automatic err(input logic [17:0] c, input logic [3:0] s);
    exec_err = 1'b1; exec_cause = c; exec_sub = s; step();
  endtask

  localparam logic [31:0] W_LOAD = 32'h0002_0301;
  localparam logic [31:0] W_AMO  = 32'h0009_0009;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) step();
    push(32'h0, 0, 0, "R1 reset state");
    step();

    wr(W_LOAD, 0, 1); push(32'h2, 1, 0, "R2 launch active");
    step();           push(32'h2, 0, 0, "R2 go single pulse");
    done(4'h5);       push(32'h14, 0, 0, "R3 done latches substatus");
    err(18'h3, 4'h1); push(32'h14, 0, 0, "R11 error ignored while idle");
    done(4'h2);       push(32'h14, 0, 0, "R11 done ignored while idle");

    wr(W_AMO, 0, 1);  push(32'h2, 1, 0, "R2 launch clears substatus");
    err(18'h200, 4'h2); push(32'h0100_8009, 0, 1, "R4 R8 R10 retryable exception with irq");
    step();           push(32'h0100_8009, 0, 0, "R10 irq single pulse");

    wr(W_LOAD, 0, 1); push(32'h2, 1, 0, "R2 relaunch clears cause");
    exec_done = 1'b1; err(18'h201, 4'h0); push(32'h0000_8041, 0, 0, "R4 R8 error wins, not retryable");

    wr(W_LOAD, 0, 1); push(32'h2, 1, 0, "R2 launch");
    err(18'h0, 4'h0); push(32'h3, 0, 0, "R5 zero cause gives call-OS");

    wr(32'h0010_0001, 0, 1); push(32'h81, 0, 0, "R6 opcode 0x10 rejected");
    wr(32'h0020_0009, 0, 1); push(32'h81, 0, 1, "R6 R10 rejected with irq");
    wr(32'h0001_0005, 0, 1); push(32'h101, 0, 0, "R7 unmapped without privilege");
    wr(32'h0001_0005, 1, 1); push(32'h2, 1, 0, "R7 unmapped with privilege");
    done(4'h8);       push(32'h20, 0, 0, "R3 implicit abort substatus bit");

    wr(W_LOAD, 0, 1); push(32'h2, 1, 0, "R2 launch");
    wr(32'h0003_0001, 0, 0); push(32'h0200_0002, 0, 0, "R9 start while active ignored, overrun");
    wr(32'h0004_0000, 0, 0); push(32'h0200_0002, 0, 0, "R9 plain write while active ignored");
    err(18'h10700, 4'h0); push(32'h0341_C001, 0, 0, "R8 R9 all transient causes, overrun sticky");
    wr(32'h0000_ABC0, 0, 1); push(32'h0341_C001, 0, 0, "R9 plain write while idle stores word");
    wr(W_LOAD, 0, 1); push(32'h2, 1, 0, "R9 accepted start clears overrun");
    done(4'h0);       push(32'h0, 0, 0, "R3 done to idle");

    step(); step();
    if (!ended) begin
      ended = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200_000 * 5);
    if (!ended) begin
      ended = 1;
      checks++; errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule